// File: doc/BRIEF.md
# CPU-to-ISA Bus Bridge

This block lets a CPU with an asynchronous, strobe-based bus reach ISA-style peripherals through a single 1 MB chip-select window. Address bit 19 splits the window. When it is 0, the access becomes an ISA I/O cycle. When it is 1, the access becomes an ISA memory cycle. When a strobe arrives inside the window, the bridge emits an address-latch pulse. It then drives the read or write command for the selected space and holds that command for a minimum count of clocks. The command is stretched further for as long as the peripheral holds its ready line low. Finally the bridge returns a data-size acknowledge to the CPU.

The bridge supports dynamic bus sizing. Each space has a 16-bit select: one for the I/O space and one for the memory space. Only the select of the space currently being accessed counts. The bridge samples it as the latch pulse ends. If that select is asserted and the CPU asks for a word (size bit 0 low), the bridge acknowledges a 16-bit port. Otherwise it acknowledges an 8-bit port.

The byte-high-enable line follows the CPU size bit directly. Data buffering is outside this block. The CPU's upper byte lane is wired to the ISA low byte. The bridge also decodes address bits 15..10 to select a disk-interface register group inside the I/O space. All inputs are treated as synchronous to `clk`.

Top module: `cpu_isa_bridge`

## Requirements
- R1: While `rst_n` is low and after it is released, `bale` is 0, all four commands (`ior_n`, `iow_n`, `memr_n`, `memw_n`) are 1 and `dsack_n` is 2'b11.
- R2: When `as_n` and `cs_n` are both sampled low in the idle state, `bale` is 1 for exactly the next clock cycle.
- R3: The command that asserts (low) depends on two sampled inputs. With `addr19`=0, `rw`=1 gives `ior_n` and `rw`=0 gives `iow_n`. With `addr19`=1, `rw`=1 gives `memr_n` and `rw`=0 gives `memw_n`. Never more than one command is low.
- R4: The command asserts in the cycle after `bale`. It stays asserted for at least CMD_MIN (default 3) cycles before the acknowledge appears.
- R5: After the minimum count, the acknowledge is given only on a clock at which `iochrdy` is sampled 1. While `iochrdy` is 0, the cycle is held off.
- R6: The 16-bit request is the I/O select's `iocs16_n` for an I/O access, or the memory select's `mcs16_n` for a memory access. It is sampled at the clock that ends `bale`. If the request is low and `siz0` is 0, the acknowledge is `dsack_n`=2'b01 (DSACK1 low). Otherwise it is 2'b10 (DSACK0 low).
- R7: When `as_n` is sampled 1, the command and the acknowledge negate in the next cycle and the bridge returns to idle. This also holds mid-cycle, which aborts the access.
- R8: `sbhe_n` equals `siz0` at all times.
- R9: `disk_sel_n` is 0 exactly when `cs_n`=0, `addr19`=0 and `addr_grp` (address bits 15..10) equals DISK_MATCH (default 6'b001000).
- R10: A strobe while `cs_n` is 1 is ignored: no `bale` and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Window chip select, active low |
| as_n | input | 1 | CPU address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr19 | input | 1 | Address bit 19: 0 I/O space, 1 memory space |
| addr_grp | input | 6 | Address bits 15..10 for the disk group decode |
| siz0 | input | 1 | CPU size bit 0 (0 = word) |
| iocs16_n | input | 1 | Peripheral 16-bit I/O select, active low |
| mcs16_n | input | 1 | Peripheral 16-bit memory select, active low |
| iochrdy | input | 1 | Peripheral ready, low stretches the cycle |
| bale | output | 1 | Address latch enable pulse |
| ior_n | output | 1 | I/O read command |
| iow_n | output | 1 | I/O write command |
| memr_n | output | 1 | Memory read command |
| memw_n | output | 1 | Memory write command |
| dsack_n | output | 2 | Size acknowledge, [1]=16-bit, [0]=8-bit, active low |
| sbhe_n | output | 1 | Byte high enable, follows siz0 |
| disk_sel_n | output | 1 | Disk register group select, active low |

## Verification
`bale` is due one clock after the strobe is sampled. The command follows one clock later. The acknowledge comes no earlier than CMD_MIN clocks after that, later by the number of clocks at which `iochrdy` was sampled low at the end of the count. Everything negates one clock after `as_n` is sampled high. `sbhe_n` and `disk_sel_n` are combinational and are due in the same cycle as their inputs. The bench advances a behavioural model at every rising edge using the inputs held since the previous falling edge. It compares every output at the falling edge, so each registered result is checked in the cycle it is due.

// File: rtl/isa_br_pkg.sv
package isa_br_pkg;
  typedef enum logic [1:0] {
    BR_IDLE = 2'd0,
    BR_ALE  = 2'd1,
    BR_CMD  = 2'd2,
    BR_ACK  = 2'd3
  } br_state_e;
endpackage

// File: rtl/isa_br_decode.sv
module isa_br_decode #(
  parameter int GRP_W = 6,
  parameter logic [GRP_W-1:0] DISK_MATCH = 6'b001000
) (
  input  logic             cs_n,
  input  logic             addr19,
  input  logic [GRP_W-1:0] addr_grp,
  input  logic             iocs16_n,
  input  logic             mcs16_n,
  output logic             io_sel_n,
  output logic             mem_sel_n,
  output logic             wide_req_n,
  output logic             disk_sel_n
);
  // space selects: bit 19 low picks I/O, high picks memory
  assign io_sel_n  = addr19 | cs_n;
  assign mem_sel_n = ~addr19 | cs_n;

  // only the 16-bit select of the active space may request a wide port
  assign wide_req_n = (iocs16_n | io_sel_n) & (mcs16_n | mem_sel_n);

  assign disk_sel_n = io_sel_n | (addr_grp != DISK_MATCH);
endmodule

// File: rtl/isa_br_seq.sv
module isa_br_seq
  import isa_br_pkg::*;
#(
  parameter int CMD_MIN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_n,
  input  logic       cs_n,
  input  logic       rw,
  input  logic       addr19,
  input  logic       siz0,
  input  logic       wide_req_n,
  input  logic       iochrdy,
  output logic       bale,
  output logic       ior_n,
  output logic       iow_n,
  output logic       memr_n,
  output logic       memw_n,
  output logic [1:0] dsack_n
);
  localparam int CNT_W = $clog2(CMD_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_MIN - 1);

  br_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             io_q, io_d;
  logic             rd_q, rd_d;
  logic             wide_q, wide_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    io_d    = io_q;
    rd_d    = rd_q;
    wide_d  = wide_q;
    if (state_q != BR_IDLE && as_n) begin
      state_d = BR_IDLE;
    end else begin
      unique case (state_q)
        BR_IDLE: begin
          if (!as_n && !cs_n) begin
            state_d = BR_ALE;
            io_d    = ~addr19;
            rd_d    = rw;
          end
        end
        BR_ALE: begin
          state_d = BR_CMD;
          cnt_d   = '0;
          wide_d  = ~(wide_req_n | siz0);
        end
        BR_CMD: begin
          if (cnt_q != CNT_LAST) cnt_d = cnt_q + 1'b1;
          else if (iochrdy)      state_d = BR_ACK;
        end
        BR_ACK: begin
          state_d = BR_ACK;
        end
        default: state_d = BR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BR_IDLE;
      cnt_q   <= '0;
      io_q    <= 1'b0;
      rd_q    <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      io_q    <= io_d;
      rd_q    <= rd_d;
      wide_q  <= wide_d;
    end
  end

  logic cmd_on;
  assign cmd_on  = (state_q == BR_CMD) || (state_q == BR_ACK);
  assign bale    = (state_q == BR_ALE);
  assign ior_n   = ~(cmd_on &  io_q &  rd_q);
  assign iow_n   = ~(cmd_on &  io_q & ~rd_q);
  assign memr_n  = ~(cmd_on & ~io_q &  rd_q);
  assign memw_n  = ~(cmd_on & ~io_q & ~rd_q);
  assign dsack_n = (state_q != BR_ACK) ? 2'b11 : (wide_q ? 2'b01 : 2'b10);
endmodule

// File: rtl/cpu_isa_bridge.sv
module cpu_isa_bridge #(
  parameter int CMD_MIN = 3,
  parameter int GRP_W = 6,
  parameter logic [GRP_W-1:0] DISK_MATCH = 6'b001000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             as_n,
  input  logic             rw,
  input  logic             addr19,
  input  logic [GRP_W-1:0] addr_grp,
  input  logic             siz0,
  input  logic             iocs16_n,
  input  logic             mcs16_n,
  input  logic             iochrdy,
  output logic             bale,
  output logic             ior_n,
  output logic             iow_n,
  output logic             memr_n,
  output logic             memw_n,
  output logic [1:0]       dsack_n,
  output logic             sbhe_n,
  output logic             disk_sel_n
);
  logic io_sel_n, mem_sel_n, wide_req_n;

  isa_br_decode #(.GRP_W(GRP_W), .DISK_MATCH(DISK_MATCH)) dec_i (
    .cs_n       (cs_n),
    .addr19     (addr19),
    .addr_grp   (addr_grp),
    .iocs16_n   (iocs16_n),
    .mcs16_n    (mcs16_n),
    .io_sel_n   (io_sel_n),
    .mem_sel_n  (mem_sel_n),
    .wide_req_n (wide_req_n),
    .disk_sel_n (disk_sel_n)
  );

  isa_br_seq #(.CMD_MIN(CMD_MIN)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .as_n       (as_n),
    .cs_n       (cs_n),
    .rw         (rw),
    .addr19     (addr19),
    .siz0       (siz0),
    .wide_req_n (wide_req_n),
    .iochrdy    (iochrdy),
    .bale       (bale),
    .ior_n      (ior_n),
    .iow_n      (iow_n),
    .memr_n     (memr_n),
    .memw_n     (memw_n),
    .dsack_n    (dsack_n)
  );

  // byte-high enable tracks the CPU size bit
  assign sbhe_n = siz0;
endmodule

// File: rtl/isa_br_checker.sv
module isa_br_checker #(
  parameter int CMD_MIN = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       as_n,
  input logic       iochrdy,
  input logic       siz0,
  input logic       bale,
  input logic       ior_n,
  input logic       iow_n,
  input logic       memr_n,
  input logic       memw_n,
  input logic [1:0] dsack_n,
  input logic       sbhe_n
);
  logic       any_cmd;
  logic [7:0] cmd_run;
  assign any_cmd = ~(ior_n & iow_n & memr_n & memw_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cmd_run <= '0;
    else if (!any_cmd)                   cmd_run <= '0;
    else if (dsack_n == 2'b11 && cmd_run != 8'hFF) cmd_run <= cmd_run + 8'd1;
  end

  p_bale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bale |=> !bale);

  p_one_command_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ior_n, ~iow_n, ~memr_n, ~memw_n}) <= 1);

  p_cmd_follows_bale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bale && !as_n) |=> any_cmd);

  p_cmd_min_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dsack_n != 2'b11 && $past(dsack_n) == 2'b11) |-> cmd_run >= 8'(CMD_MIN));

  p_ack_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dsack_n != 2'b11 && $past(dsack_n) == 2'b11) |-> $past(iochrdy));

  p_single_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dsack_n != 2'b00);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (dsack_n == 2'b11 && !any_cmd));

  p_sbhe_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sbhe_n == siz0);
endmodule

bind cpu_isa_bridge isa_br_checker #(.CMD_MIN(CMD_MIN)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .as_n    (as_n),
  .iochrdy (iochrdy),
  .siz0    (siz0),
  .bale    (bale),
  .ior_n   (ior_n),
  .iow_n   (iow_n),
  .memr_n  (memr_n),
  .memw_n  (memw_n),
  .dsack_n (dsack_n),
  .sbhe_n  (sbhe_n)
);

// File: tb/cpu_isa_bridge_tb_top.sv
`timescale 1ns/1ps
module cpu_isa_bridge_tb_top;
  localparam int CMD_MIN = 3;
  localparam logic [5:0] DISK = 6'b001000;

  logic clk = 1'b0;
  logic rst_n, cs_n, as_n, rw, addr19, siz0, iocs16_n, mcs16_n, iochrdy;
  logic [5:0] addr_grp;
  logic bale, ior_n, iow_n, memr_n, memw_n, sbhe_n, disk_sel_n;
  logic [1:0] dsack_n;

  always #2.5 clk = ~clk;

  cpu_isa_bridge #(.CMD_MIN(CMD_MIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .rw(rw),
    .addr19(addr19), .addr_grp(addr_grp), .siz0(siz0),
    .iocs16_n(iocs16_n), .mcs16_n(mcs16_n), .iochrdy(iochrdy),
    .bale(bale), .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n),
    .memw_n(memw_n), .dsack_n(dsack_n), .sbhe_n(sbhe_n),
    .disk_sel_n(disk_sel_n)
  );

  int total = 0;
  int bad = 0;

  // behavioural reference: phase 0 idle, 1 latch pulse, 2 command, 3 acknowledged
  int m_phase = 0;
  int m_cnt = 0;
  bit m_io, m_rd, m_wide;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_phase = 0;
    end else if (m_phase != 0 && as_n) begin
      m_phase = 0;
    end else if (m_phase == 0) begin
      if (!as_n && !cs_n) begin
        m_phase = 1; m_io = !addr19; m_rd = rw;
      end
    end else if (m_phase == 1) begin
      m_wide = (m_io ? !iocs16_n : !mcs16_n) && !siz0;
      m_phase = 2; m_cnt = 1;
    end else if (m_phase == 2) begin
      if (m_cnt < CMD_MIN) m_cnt++;
      else if (iochrdy) m_phase = 3;
    end
  endtask

  task automatic compare();
    bit on;
    logic [3:0] exp_cmd;
    logic [1:0] exp_ack;
    bit exp_disk;
    on = (m_phase >= 2);
    exp_cmd = {!(on && m_io && m_rd), !(on && m_io && !m_rd),
               !(on && !m_io && m_rd), !(on && !m_io && !m_rd)};
    exp_ack = (m_phase != 3) ? 2'b11 : (m_wide ? 2'b01 : 2'b10);
    exp_disk = !(!cs_n && !addr19 && addr_grp == DISK);
    chk(bale == (m_phase == 1), "R2 bale", int'(bale), int'(m_phase == 1));
    chk({ior_n, iow_n, memr_n, memw_n} == exp_cmd, "R3 R4 commands",
        int'({ior_n, iow_n, memr_n, memw_n}), int'(exp_cmd));
    chk(dsack_n == exp_ack, "R5 R6 dsack", int'(dsack_n), int'(exp_ack));
    chk(sbhe_n == siz0, "R8 sbhe", int'(sbhe_n), int'(siz0));
    chk(disk_sel_n == exp_disk, "R9 disk select", int'(disk_sel_n), int'(exp_disk));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic bus_cycle(input bit a19, input bit r, input bit s0,
                           input bit io16n, input bit m16n, input int waits);
    int left;
    addr19 = a19; rw = r; siz0 = s0; iocs16_n = io16n; mcs16_n = m16n;
    cs_n = 1'b0; as_n = 1'b0;
    left = waits;
    iochrdy = (left == 0);
    for (int i = 0; i < 60; i++) begin
      step();
      if (left > 0) begin
        left--;
        if (left == 0) iochrdy = 1'b1;
      end
      if (dsack_n != 2'b11) break;
    end
    as_n = 1'b1;
    step();
    // R7: one clock after the strobe negates, everything is idle
    chk(dsack_n == 2'b11 && {ior_n, iow_n, memr_n, memw_n} == 4'hF, "R7 release",
        int'({dsack_n, ior_n, iow_n, memr_n, memw_n}), 'h3F);
    cs_n = 1'b1;
    step();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; as_n = 1'b1; rw = 1'b1; addr19 = 1'b0;
    addr_grp = 6'd0; siz0 = 1'b0; iocs16_n = 1'b1; mcs16_n = 1'b1; iochrdy = 1'b1;
    repeat (3) step();
    // R1: idle outputs under reset
    chk(!bale && {ior_n, iow_n, memr_n, memw_n} == 4'hF && dsack_n == 2'b11,
        "R1 reset", int'({bale, ior_n, iow_n, memr_n, memw_n, dsack_n}), 'h3F);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk(!bale && dsack_n == 2'b11, "R1 after release", int'({bale, dsack_n}), 3);

    bus_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0);  // I/O read, word, 16-bit I/O
    bus_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0);  // I/O write, byte -> 8-bit
    bus_cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0);  // memory read, 16-bit memory
    bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0);  // R6: wrong-space select ignored
    bus_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0);  // R6: wrong-space select ignored
    bus_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9);  // R5: stretched by iochrdy
    bus_cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12); // R5: longer stretch

    // R7: abort while the command is active
    addr19 = 1'b1; rw = 1'b0; cs_n = 1'b0; as_n = 1'b0; iochrdy = 1'b0;
    repeat (3) step();
    chk(memw_n == 1'b0, "R7 command active before abort", int'(memw_n), 0);
    as_n = 1'b1;
    step();
    chk(memw_n == 1'b1 && dsack_n == 2'b11, "R7 abort", int'({memw_n, dsack_n}), 7);
    iochrdy = 1'b1; cs_n = 1'b1;
    step();

    // R10: strobe outside the window
    cs_n = 1'b1; as_n = 1'b0;
    repeat (4) step();
    chk(!bale && {ior_n, iow_n, memr_n, memw_n} == 4'hF, "R10 no select",
        int'({bale, ior_n, iow_n, memr_n, memw_n}), 'hF);
    as_n = 1'b1;
    step();

    // R9: disk group decode patterns
    cs_n = 1'b0; addr19 = 1'b0; addr_grp = DISK;
    step();
    chk(disk_sel_n == 1'b0, "R9 match", int'(disk_sel_n), 0);
    addr_grp = 6'b001001;
    step();
    chk(disk_sel_n == 1'b1, "R9 other group", int'(disk_sel_n), 1);
    addr19 = 1'b1; addr_grp = DISK;
    step();
    chk(disk_sel_n == 1'b1, "R9 memory space", int'(disk_sel_n), 1);
    cs_n = 1'b1;
    step();

    // R8: size bit toggles pass straight through
    siz0 = 1'b1; #1;
    chk(sbhe_n == 1'b1, "R8 high", int'(sbhe_n), 1);
    siz0 = 1'b0; #1;
    chk(sbhe_n == 1'b0, "R8 low", int'(sbhe_n), 0);
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule